// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command-register state machine of a byte-wide parallel NOR flash. It watches bus write strobes, each carrying an address and a data byte. It recognizes the multi-write unlock-and-command sequences that software uses to start array operations. When a sequence completes, it raises a one-cycle request towards the array controller. The requests are byte program (with target address and data), full-chip erase, sector erase (with the sector address), boot-block lock and return-to-read.

Every command except the single-write reset starts with the same two-write unlock key. After the key, a command byte selects the branch. Erase-class commands repeat the key before their final byte. A write that does not fit the expected next step drops the decoder back to idle and array-read mode. A level output tells the read path to return identifier codes instead of array data. It is set by the identifier command and cleared by reset or by any aborted or completed sequence. While the array controller reports busy, completed writes are discarded and leave the sequence state untouched.

The write strobe is a level signal. The address is taken on its first high cycle, and the data on the cycle it falls.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, all request outputs are low and `id_mode` is 0 (array read).
- R2: Writes AAh@5555h, 55h@2AAAh, A0h@5555h, then any address/data raise `req_prog` for exactly one cycle. `op_addr` and `op_data` carry the fourth write's address and data.
- R3: Writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 10h@5555h raise `req_chip_erase` for one cycle.
- R4: The same first five writes as R3, followed by 30h at any address, raise `req_sector_erase` for one cycle, with `op_addr` equal to that address.
- R5: The same first five writes as R3, followed by 40h@5555h, raise `req_boot_lock` for one cycle.
- R6: From idle, a single write of F0h to any address raises `req_reset` for one cycle.
- R7: The three writes AAh@5555h, 55h@2AAAh, F0h@5555h also raise `req_reset` for one cycle.
- R8: A write whose address or data does not match the next expected step returns the decoder to idle. It issues no request and clears `id_mode`. A later command byte without its unlock key then has no effect.
- R9: Only the low 16 address bits are compared with 5555h and 2AAAh. Address bits 17 and 16 are ignored for matching, but `op_addr` carries all 18 bits.
- R10: The address of a write is taken in the first cycle `bus_wr` is high. The data is taken in the cycle `bus_wr` is low again. The request is visible in the following cycle.
- R11: Writes AAh@5555h, 55h@2AAAh, 90h@5555h set `id_mode` to 1 (identifier read). It stays 1 until a reset command or an aborting or completing write clears it. A reset request is never issued with `id_mode` still 1.
- R12: A write that completes while `busy` is high is ignored. The sequence state does not advance or abort, and no request is issued.
- R13: At most one request output is high in any cycle, and no request stays high for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, high for the duration of a bus write |
| bus_addr | input | 18 | Write address, sampled on the first strobe cycle |
| bus_data | input | 8 | Write data, sampled when the strobe falls |
| busy | input | 1 | Array controller busy; completed writes are ignored while high |
| req_prog | output | 1 | One-cycle byte program request |
| req_chip_erase | output | 1 | One-cycle full-chip erase request |
| req_sector_erase | output | 1 | One-cycle sector erase request |
| req_boot_lock | output | 1 | One-cycle boot-block lock request |
| req_reset | output | 1 | One-cycle return-to-read request |
| op_addr | output | 18 | Program address or sector address of the current request |
| op_data | output | 8 | Program data of the current request |
| id_mode | output | 1 | 1 selects identifier read, 0 selects array read |

## Verification
The sequence state is visible only indirectly. It shows up as a missing, extra or wrong request on the write that would complete a command. It also shows up in the `id_mode` level. A stuck or mis-advanced state is therefore exposed one cycle after the final write of the next sequence. The bench completes every command branch, aborts at different depths and interleaves busy writes, so a wrong state appears on the next completion attempt. Address and data capture errors show up as a wrong `op_addr` or `op_data` on the same request cycle.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int KEY_W = 16;
    localparam int CMD_W = 8;

    localparam logic [KEY_W-1:0] KEY_ADDR_A = 16'h5555;
    localparam logic [KEY_W-1:0] KEY_ADDR_B = 16'h2AAA;

    localparam logic [CMD_W-1:0] CMD_KEY1   = 8'hAA;
    localparam logic [CMD_W-1:0] CMD_KEY2   = 8'h55;
    localparam logic [CMD_W-1:0] CMD_PROG   = 8'hA0;
    localparam logic [CMD_W-1:0] CMD_ERASE  = 8'h80;
    localparam logic [CMD_W-1:0] CMD_IDENT  = 8'h90;
    localparam logic [CMD_W-1:0] CMD_RESET  = 8'hF0;
    localparam logic [CMD_W-1:0] CMD_CHIP   = 8'h10;
    localparam logic [CMD_W-1:0] CMD_SECTOR = 8'h30;
    localparam logic [CMD_W-1:0] CMD_BOOT   = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY1,
        ST_KEY2,
        ST_PROG,
        ST_ERS_SETUP,
        ST_ERS_KEY1,
        ST_ERS_KEY2
    } seq_state_e;

endpackage

// File: rtl/flash_bus_capture.sv
module flash_bus_capture #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              wr_done,
    output logic [ADDR_W-1:0] done_addr,
    output logic [DATA_W-1:0] done_data
);

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d    = cap_q;
        cap_d.wr = bus_wr;
        if (bus_wr && !cap_q.wr) begin
            cap_d.addr = bus_addr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign wr_done   = cap_q.wr && !bus_wr;
    assign done_addr = cap_q.addr;
    assign done_data = bus_data;

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_done,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_sector_erase,
    output logic              req_boot_lock,
    output logic              req_reset,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode
);

    typedef struct packed {
        seq_state_e        st;
        logic              id;
        logic              prog;
        logic              chip;
        logic              sect;
        logic              boot;
        logic              rst;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [KEY_W-1:0] key;
    logic [CMD_W-1:0] cmd;
    logic             at_a;
    logic             at_b;

    assign key  = wr_addr[KEY_W-1:0];
    assign cmd  = wr_data[CMD_W-1:0];
    assign at_a = (key == KEY_ADDR_A);
    assign at_b = (key == KEY_ADDR_B);

    always_comb begin
        f_d      = f_q;
        f_d.prog = 1'b0;
        f_d.chip = 1'b0;
        f_d.sect = 1'b0;
        f_d.boot = 1'b0;
        f_d.rst  = 1'b0;
        if (wr_done && !busy) begin
            f_d.st = ST_IDLE;
            f_d.id = 1'b0;
            case (f_q.st)
                ST_IDLE: begin
                    if (at_a && cmd == CMD_KEY1) begin
                        f_d.st = ST_KEY1;
                        f_d.id = f_q.id;
                    end else if (cmd == CMD_RESET) begin
                        f_d.rst = 1'b1;
                    end
                end
                ST_KEY1: begin
                    if (at_b && cmd == CMD_KEY2) begin
                        f_d.st = ST_KEY2;
                        f_d.id = f_q.id;
                    end
                end
                ST_KEY2: begin
                    if (at_a) begin
                        case (cmd)
                            CMD_PROG:  begin f_d.st = ST_PROG;      f_d.id = f_q.id; end
                            CMD_ERASE: begin f_d.st = ST_ERS_SETUP; f_d.id = f_q.id; end
                            CMD_IDENT: f_d.id  = 1'b1;
                            CMD_RESET: f_d.rst = 1'b1;
                            default:   f_d.id  = 1'b0;
                        endcase
                    end
                end
                ST_PROG: begin
                    f_d.prog = 1'b1;
                    f_d.addr = wr_addr;
                    f_d.data = wr_data;
                end
                ST_ERS_SETUP: begin
                    if (at_a && cmd == CMD_KEY1) begin
                        f_d.st = ST_ERS_KEY1;
                        f_d.id = f_q.id;
                    end
                end
                ST_ERS_KEY1: begin
                    if (at_b && cmd == CMD_KEY2) begin
                        f_d.st = ST_ERS_KEY2;
                        f_d.id = f_q.id;
                    end
                end
                ST_ERS_KEY2: begin
                    if (cmd == CMD_SECTOR) begin
                        f_d.sect = 1'b1;
                        f_d.addr = wr_addr;
                    end else if (at_a && cmd == CMD_CHIP) begin
                        f_d.chip = 1'b1;
                    end else if (at_a && cmd == CMD_BOOT) begin
                        f_d.boot = 1'b1;
                    end
                end
                default: f_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q    <= '0;
            f_q.st <= ST_IDLE;
        end else begin
            f_q <= f_d;
        end
    end

    assign req_prog         = f_q.prog;
    assign req_chip_erase   = f_q.chip;
    assign req_sector_erase = f_q.sect;
    assign req_boot_lock    = f_q.boot;
    assign req_reset        = f_q.rst;
    assign op_addr          = f_q.addr;
    assign op_data          = f_q.data;
    assign id_mode          = f_q.id;

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    input  logic              busy,
    output logic              req_prog,
    output logic              req_chip_erase,
    output logic              req_sector_erase,
    output logic              req_boot_lock,
    output logic              req_reset,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic              id_mode
);

    logic              wr_done;
    logic [ADDR_W-1:0] done_addr;
    logic [DATA_W-1:0] done_data;

    flash_bus_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .wr_done   (wr_done),
        .done_addr (done_addr),
        .done_data (done_data)
    );

    flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk              (clk),
        .rst_n            (rst_n),
        .wr_done          (wr_done),
        .wr_addr          (done_addr),
        .wr_data          (done_data),
        .busy             (busy),
        .req_prog         (req_prog),
        .req_chip_erase   (req_chip_erase),
        .req_sector_erase (req_sector_erase),
        .req_boot_lock    (req_boot_lock),
        .req_reset        (req_reset),
        .op_addr          (op_addr),
        .op_data          (op_data),
        .id_mode          (id_mode)
    );

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_data,
    input logic              busy,
    input logic              req_prog,
    input logic              req_chip_erase,
    input logic              req_sector_erase,
    input logic              req_boot_lock,
    input logic              req_reset,
    input logic [ADDR_W-1:0] op_addr,
    input logic [DATA_W-1:0] op_data,
    input logic              id_mode
);

    logic [4:0] reqs;
    logic       any_req;

    assign reqs    = {req_prog, req_chip_erase, req_sector_erase, req_boot_lock, req_reset};
    assign any_req = |reqs;

    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reqs)); // R13

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> !any_req); // R13

    AST_REQ_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> (!$past(bus_wr) && $past(bus_wr, 2))); // R10

    AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |-> !$past(busy)); // R12

    AST_RESET_LEAVES_ID: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset |-> !id_mode); // R11

    AST_ID_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(id_mode) |-> (!$past(bus_wr) && !$past(busy))); // R11

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam int AW = 18;
    localparam int DW = 8;

    localparam int K_PROG = 0;
    localparam int K_CHIP = 1;
    localparam int K_SECT = 2;
    localparam int K_BOOT = 3;
    localparam int K_RST  = 4;

    typedef struct {
        int          kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        string       tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic          busy = 1'b0;
    logic          req_prog, req_chip_erase, req_sector_erase, req_boot_lock, req_reset;
    logic [AW-1:0] op_addr;
    logic [DW-1:0] op_data;
    logic          id_mode;

    int   checks = 0;
    int   fails  = 0;
    bit   finished = 1'b0;
    exp_t sb[$];

    always #4 clk = ~clk;

    flash_cmd_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_data(bus_data), .busy(busy), .req_prog(req_prog),
        .req_chip_erase(req_chip_erase), .req_sector_erase(req_sector_erase),
        .req_boot_lock(req_boot_lock), .req_reset(req_reset),
        .op_addr(op_addr), .op_data(op_data), .id_mode(id_mode)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [AW-1:0] a, input logic [DW-1:0] d, input string tag);
        exp_t e;
        e.kind = kind; e.addr = a; e.data = d; e.tag = tag;
        sb.push_back(e);
    endtask

    // One bus write: address valid only on the first strobe cycle, data valid only at the fall
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_data = 8'hC3;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = ~a; bus_data = d;
        @(negedge clk);
        bus_data = 8'h00;
    endtask

    task automatic key();
        wr(18'h05555, 8'hAA);
        wr(18'h02AAA, 8'h55);
    endtask

    task automatic erase_prefix();
        key();
        wr(18'h05555, 8'h80);
        key();
    endtask

    task automatic drain(input string tag);
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, tag, sb.size(), 0);
        sb.delete();
    endtask

    // Monitor: pops expected items as requests appear
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [4:0] r;
            r = {req_reset, req_boot_lock, req_sector_erase, req_chip_erase, req_prog};
            if (r != 0) begin
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected request", r, 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(r == (5'd1 << e.kind), e.tag, r, 5'd1 << e.kind);
                    if (e.kind == K_PROG) begin
                        chk(op_addr == e.addr, e.tag, op_addr, e.addr);
                        chk(op_data == e.data, e.tag, op_data, e.data);
                    end else if (e.kind == K_SECT) begin
                        chk(op_addr == e.addr, e.tag, op_addr, e.addr);
                    end
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk({req_prog, req_chip_erase, req_sector_erase, req_boot_lock, req_reset} == 0,
            "R1 requests after reset", {req_prog, req_chip_erase, req_sector_erase, req_boot_lock, req_reset}, 0);
        chk(id_mode == 1'b0, "R1 id_mode after reset", id_mode, 0);

        // R2 program
        key(); wr(18'h05555, 8'hA0);
        push(K_PROG, 18'h21234, 8'h5A, "R2 program");
        wr(18'h21234, 8'h5A);
        drain("R2 drain");

        // R10 capture points: second program with distinct values
        key(); wr(18'h05555, 8'hA0);
        push(K_PROG, 18'h00F0F, 8'hA5, "R10 capture");
        wr(18'h00F0F, 8'hA5);
        drain("R10 drain");

        // R3 chip erase
        erase_prefix();
        push(K_CHIP, '0, '0, "R3 chip erase");
        wr(18'h05555, 8'h10);
        drain("R3 drain");

        // R4 sector erase at arbitrary address
        erase_prefix();
        push(K_SECT, 18'h3C000, '0, "R4 sector erase");
        wr(18'h3C000, 8'h30);
        drain("R4 drain");

        // R5 boot lock
        erase_prefix();
        push(K_BOOT, '0, '0, "R5 boot lock");
        wr(18'h05555, 8'h40);
        drain("R5 drain");

        // R6 single-write reset at arbitrary address
        push(K_RST, '0, '0, "R6 single reset");
        wr(18'h1ABCD, 8'hF0);
        drain("R6 drain");

        // R11 identifier mode entry and exit through three-write reset (R7)
        key(); wr(18'h05555, 8'h90);
        chk(id_mode == 1'b1, "R11 id entry", id_mode, 1);
        key();
        chk(id_mode == 1'b1, "R11 id held mid-sequence", id_mode, 1);
        push(K_RST, '0, '0, "R7 three-write reset");
        wr(18'h05555, 8'hF0);
        chk(id_mode == 1'b0, "R11 id cleared by reset", id_mode, 0);
        drain("R7 drain");

        // R8 mismatch aborts and clears id mode; orphan command byte does nothing
        key(); wr(18'h05555, 8'h90);
        wr(18'h05555, 8'hAA);
        wr(18'h02AAB, 8'h55);
        chk(id_mode == 1'b0, "R8 id cleared by mismatch", id_mode, 0);
        wr(18'h05555, 8'hA0);
        wr(18'h01234, 8'h77);
        drain("R8 no request");
        erase_prefix();
        wr(18'h05555, 8'h11);
        drain("R8 wrong final byte");

        // R9 upper address bits ignored for keys
        wr(18'h15555, 8'hAA);
        wr(18'h32AAA, 8'h55);
        wr(18'h25555, 8'hA0);
        push(K_PROG, 18'h3FFFF, 8'h01, "R9 upper bits");
        wr(18'h3FFFF, 8'h01);
        drain("R9 drain");

        // R12 busy: ignored writes neither advance nor abort
        key();
        busy = 1'b1;
        wr(18'h01111, 8'h22);
        busy = 1'b0;
        wr(18'h05555, 8'hA0);
        busy = 1'b1;
        wr(18'h04444, 8'h44);
        drain("R12 no request while busy");
        busy = 1'b0;
        push(K_PROG, 18'h06666, 8'h66, "R12 sequence kept");
        wr(18'h06666, 8'h66);
        drain("R12 drain");

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule